// File: doc/BRIEF.md
# Spare Status Stripper and Error Tally

This block sits on the byte stream that leaves an ECC engine after a page read. In that stream each chunk's spare bytes are followed by a four-byte status record. The block passes the spare bytes to the host as one contiguous stream and drops every status record. It reads the first byte of each record as the chunk's result and keeps per-page statistics: the largest number of bits corrected in any one chunk, the total of corrected bits, the number of chunks that could not be corrected, and a page failure flag.

Both streams use a valid/ready handshake with an end marker. The spare step size (1 to 255 bytes) and the chunk count (1 to 16) are configuration inputs. They must be held stable while a page is in flight. The statistics clear on the first byte of each page. A one-cycle done pulse marks the point at which they describe the whole page.

Top module: `spare_status_stripper`

## Requirements
- R1: Spare bytes leave on `out_data` in their input order with no gaps between chunks, and none of the four status bytes of any chunk reaches the output.
- R2: While a spare byte is offered, `in_ready` equals `out_ready`. A status byte is always accepted (`in_ready` high, `out_valid` low), whatever the level of `out_ready`.
- R3: `out_last` is high together with the final spare byte of the final chunk, and low with every other output byte.
- R4: A status code of 0x00 (clean) or 0xFF (erased) leaves the maximum, the sum, the failure count and the failure flag unchanged.
- R5: A status code of 0xFE, or any code above 0x28, adds one to the failure count and sets the page failure flag. 0x29 is the lowest such code.
- R6: A status code from 0x01 to 0x28 inclusive adds its value to the corrected sum and raises the maximum if it is larger.
- R7: Only the first byte of a four-byte status record is classified. The other three bytes have no effect on any statistic.
- R8: All statistics read zero once the first byte of a page has been accepted. `stat_done` pulses for exactly one cycle, in the cycle after the last status byte of the final chunk is accepted, and the statistics are complete in that cycle.
- R9: An input byte accepted with `in_last` high returns the block to the start of a page. If this ends a page early, no `stat_done` pulse follows.
- R10: After reset the statistics are zero, `stat_done` and `out_valid` are low, and the block expects the first spare byte of a page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_step | input | 8 | Spare bytes per chunk (1..255) |
| cfg_chunks | input | 5 | Chunks per page (1..16) |
| in_data | input | 8 | Input byte from the ECC engine |
| in_valid | input | 1 | Input byte valid |
| in_last | input | 1 | Input end-of-page marker |
| in_ready | output | 1 | Block accepts the input byte |
| out_data | output | 8 | Spare byte to the host |
| out_valid | output | 1 | Output byte valid |
| out_last | output | 1 | Final spare byte of the page |
| out_ready | input | 1 | Host accepts the output byte |
| stat_done | output | 1 | One-cycle pulse: page statistics complete |
| stat_max | output | 8 | Largest corrected count of any chunk |
| stat_sum | output | 10 | Sum of corrected bits over the page |
| stat_fail_cnt | output | 5 | Number of uncorrectable chunks |
| stat_page_fail | output | 1 | At least one chunk was uncorrectable |

## Verification
The data path is combinational. `out_valid`, `out_data`, `out_last` and `in_ready` are due in the same cycle that a byte is offered, so the bench samples them 1 ns after it drives the inputs and before the next rising edge. Each statistic register updates on the edge that accepts the status byte. `stat_done` rises on the edge that accepts the final record byte and falls one edge later. The bench therefore reads the results 1 ns after that accepting edge, and checks that `stat_done` is low 1 ns after the following edge. The clearing of the statistics is checked 1 ns after the edge that accepts the first byte of a page.

// File: rtl/spare_strip_pkg.sv
// Shared status codes and the classification type for the spare stripper.
package spare_strip_pkg;
    localparam int unsigned CODE_W        = 8;
    localparam logic [7:0]  CODE_CLEAN    = 8'h00;
    localparam logic [7:0]  CODE_ERASED   = 8'hFF;
    localparam logic [7:0]  CODE_UNCORR   = 8'hFE;
    localparam logic [7:0]  CODE_MAX_CORR = 8'h28;

    typedef enum logic [1:0] {
        KIND_CLEAN  = 2'd0,
        KIND_ERASED = 2'd1,
        KIND_CORR   = 2'd2,
        KIND_FAIL   = 2'd3
    } status_kind_e;
endpackage

// File: rtl/sst_position.sv
// Tracks the byte position inside the chunk record and the chunk within the page.
// Assumes cfg_step >= 1, 1 <= cfg_chunks <= 2**CHUNK_W-1, and config stable within a page.
module sst_position #(
    parameter int unsigned STEP_W     = 8,
    parameter int unsigned CHUNK_W    = 5,
    parameter int unsigned STAT_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [CHUNK_W-1:0] cfg_chunks,
    input  logic               accept,
    input  logic               acc_last,
    output logic               is_spare,
    output logic               is_stat_head,
    output logic               is_page_start,
    output logic               is_final,
    output logic               is_out_last
);
    localparam int unsigned IDX_W = STEP_W + 1;

    logic [IDX_W-1:0]   byte_q;
    logic [CHUNK_W-1:0] chunk_q;
    logic [IDX_W-1:0]   rec_end;
    logic [IDX_W-1:0]   step_ext;
    logic               last_chunk;

    // Position decode derived from the counters and configuration.
    always_comb begin
        step_ext      = IDX_W'(cfg_step);
        rec_end       = step_ext + IDX_W'(STAT_BYTES - 1);
        last_chunk    = (chunk_q == cfg_chunks - CHUNK_W'(1));
        is_spare      = (byte_q < step_ext);
        is_stat_head  = (byte_q == step_ext);
        is_page_start = (byte_q == '0) && (chunk_q == '0);
        is_final      = last_chunk && (byte_q == rec_end);
        is_out_last   = last_chunk && (byte_q == step_ext - IDX_W'(1));
    end

    // Advance on every accepted byte; wrap at record and page ends or on the end marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q  <= '0;
            chunk_q <= '0;
        end else if (accept) begin
            if (acc_last || is_final) begin
                byte_q  <= '0;
                chunk_q <= '0;
            end else if (byte_q == rec_end) begin
                byte_q  <= '0;
                chunk_q <= chunk_q + CHUNK_W'(1);
            end else begin
                byte_q <= byte_q + IDX_W'(1);
            end
        end
    end

    // R1: the record counter never runs past the end of the status record.
    assert_idx_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        byte_q <= rec_end);

    // R9: an accepted end marker always lands the block at the page start.
    assert_last_resync_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && acc_last) |=> is_page_start);
endmodule

// File: rtl/sst_classify.sv
// Maps one status code to its kind and to the number of corrected bits it reports.
// Purely combinational; corrected bits are zero for every kind except corrected.
module sst_classify
    import spare_strip_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output status_kind_e      kind,
    output logic [CODE_W-1:0] corr_bits
);
    // Decode order: clean, erased, uncorrectable, otherwise a corrected count.
    always_comb begin
        if (code == CODE_CLEAN)
            kind = KIND_CLEAN;
        else if (code == CODE_ERASED)
            kind = KIND_ERASED;
        else if ((code == CODE_UNCORR) || (code > CODE_MAX_CORR))
            kind = KIND_FAIL;
        else
            kind = KIND_CORR;
        corr_bits = (kind == KIND_CORR) ? code : '0;
    end
endmodule

// File: rtl/sst_tally.sv
// Holds the page statistics: running maximum, corrected sum, failure count and flag.
// clr starts a new page; upd folds in one classified chunk (never both in one cycle).
module sst_tally
    import spare_strip_pkg::*;
#(
    parameter int unsigned SUM_W  = 10,
    parameter int unsigned FCNT_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               upd,
    input  status_kind_e       kind,
    input  logic [CODE_W-1:0]  corr_bits,
    output logic [CODE_W-1:0]  max_q,
    output logic [SUM_W-1:0]   sum_q,
    output logic [FCNT_W-1:0]  fcnt_q,
    output logic               pfail_q
);
    // Clear on page start, otherwise accumulate the chunk result.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            max_q   <= '0;
            sum_q   <= '0;
            fcnt_q  <= '0;
            pfail_q <= 1'b0;
        end else if (upd) begin
            if (kind == KIND_FAIL) begin
                fcnt_q  <= fcnt_q + FCNT_W'(1);
                pfail_q <= 1'b1;
            end else if (kind == KIND_CORR) begin
                sum_q <= sum_q + SUM_W'(corr_bits);
                if (corr_bits > max_q)
                    max_q <= corr_bits;
            end
        end
    end

    // R5: the failure flag is set exactly when some chunk has failed.
    assert_flag_matches_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pfail_q == (fcnt_q != '0));

    // R6: the largest chunk count can never exceed the page sum.
    assert_max_within_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
        SUM_W'(max_q) <= sum_q);

    // R7: statistics move only on a classified status byte or a page clear.
    assert_stable_without_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !clr) |=> ($stable(sum_q) && $stable(fcnt_q) && $stable(max_q)));
endmodule

// File: rtl/spare_status_stripper.sv
// Strips four-byte status records from a read-side spare stream and tallies chunk results.
// Spare bytes flow through combinationally under output backpressure; status bytes are
// swallowed unconditionally. Configuration must be stable while a page is in flight.
module spare_status_stripper
    import spare_strip_pkg::*;
#(
    parameter int unsigned STEP_W     = 8,
    parameter int unsigned MAX_CHUNKS = 16,
    parameter int unsigned STAT_BYTES = 4,
    localparam int unsigned CHUNK_W   = $clog2(MAX_CHUNKS + 1),
    localparam int unsigned SUM_W     = $clog2(MAX_CHUNKS * 40 + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [CHUNK_W-1:0] cfg_chunks,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    input  logic               in_last,
    output logic               in_ready,
    output logic [7:0]         out_data,
    output logic               out_valid,
    output logic               out_last,
    input  logic               out_ready,
    output logic               stat_done,
    output logic [7:0]         stat_max,
    output logic [SUM_W-1:0]   stat_sum,
    output logic [CHUNK_W-1:0] stat_fail_cnt,
    output logic               stat_page_fail
);
    logic         is_spare, is_stat_head, is_page_start, is_final, is_out_last;
    logic         accept;
    logic         done_q;
    status_kind_e kind;
    logic [7:0]   corr_bits;

    // Stream steering: spare bytes need the host, status bytes do not.
    always_comb begin
        in_ready  = is_spare ? out_ready : 1'b1;
        out_valid = in_valid && is_spare;
        out_data  = in_data;
        out_last  = out_valid && is_out_last;
        accept    = in_valid && in_ready;
    end

    sst_position #(
        .STEP_W    (STEP_W),
        .CHUNK_W   (CHUNK_W),
        .STAT_BYTES(STAT_BYTES)
    ) u_pos (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_step     (cfg_step),
        .cfg_chunks   (cfg_chunks),
        .accept       (accept),
        .acc_last     (in_last),
        .is_spare     (is_spare),
        .is_stat_head (is_stat_head),
        .is_page_start(is_page_start),
        .is_final     (is_final),
        .is_out_last  (is_out_last)
    );

    sst_classify u_cls (
        .code     (in_data),
        .kind     (kind),
        .corr_bits(corr_bits)
    );

    sst_tally #(
        .SUM_W (SUM_W),
        .FCNT_W(CHUNK_W)
    ) u_tally (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (accept && is_page_start),
        .upd      (accept && is_stat_head),
        .kind     (kind),
        .corr_bits(corr_bits),
        .max_q    (stat_max),
        .sum_q    (stat_sum),
        .fcnt_q   (stat_fail_cnt),
        .pfail_q  (stat_page_fail)
    );

    // Done pulse after the final record byte completes a page without an early end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= accept && is_final;
    end
    assign stat_done = done_q;

    // R8: done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_done |=> !stat_done);

    // R3: the end marker on the output only travels with a valid byte.
    assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2: an offered byte that is not forwarded must be taken anyway.
    assert_status_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !out_valid) |-> in_ready);

    // R2: a forwarded byte is accepted exactly when the host takes it.
    assert_spare_follows_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_ready == out_ready));
endmodule

// File: tb/spare_status_stripper_tb.sv
module spare_status_stripper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_step = 8'd3;
    logic [4:0]  cfg_chunks = 5'd2;
    logic [7:0]  in_data = '0;
    logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
    logic        in_ready, out_valid, out_last, stat_done, stat_page_fail;
    logic [7:0]  out_data, stat_max;
    logic [9:0]  stat_sum;
    logic [4:0]  stat_fail_cnt;

    int checks = 0, errors = 0;
    logic [7:0] cap [0:4095];
    logic       caplast [0:4095];
    int ncap;

    always #5 clk = ~clk;

    spare_status_stripper u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_step(cfg_step), .cfg_chunks(cfg_chunks),
        .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
        .stat_done(stat_done), .stat_max(stat_max), .stat_sum(stat_sum),
        .stat_fail_cnt(stat_fail_cnt), .stat_page_fail(stat_page_fail)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one byte; hold out_ready at rdy first, then release it if the byte stalls.
    task automatic send_byte(input logic [7:0] d, input logic lst, input logic rdy, input logic is_stat);
        @(negedge clk);
        in_data = d; in_last = lst; in_valid = 1'b1; out_ready = rdy;
        #1;
        if (!rdy) begin
            if (is_stat) chk(in_ready && !out_valid, "R2 status taken without host", int'(in_ready), 1);
            else begin
                chk(!in_ready, "R2 spare stalls on host", int'(in_ready), 0);
                @(negedge clk); out_ready = 1'b1; #1;
            end
        end
        if (out_valid && out_ready) begin
            cap[ncap] = out_data; caplast[ncap] = out_last; ncap++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    // Send a full page, then check output bytes, end marker, statistics and the done pulse.
    task automatic run_page(input int step, input int chunks, input logic [7:0] st [16],
                            input logic [7:0] fill, input logic alt_rdy, input logic [7:0] seed,
                            input string tag);
        int n = 0, emax = 0, esum = 0, efail = 0, bad = 0, badlast = 0;
        cfg_step = 8'(step); cfg_chunks = 5'(chunks); ncap = 0;
        for (int c = 0; c < chunks; c++) begin
            for (int b = 0; b < step + 4; b++) begin
                logic [7:0] d;
                logic isst;
                isst = (b >= step);
                d = isst ? ((b == step) ? st[c] : fill) : 8'(seed + c * step + b);
                send_byte(d, (c == chunks - 1) && (b == step + 3), alt_rdy ? logic'(n % 2) : 1'b1, isst);
                if (n == 0)
                    chk(stat_sum == 0 && stat_fail_cnt == 0 && !stat_page_fail && stat_max == 0,
                        {"R8 clear at page start ", tag}, int'(stat_sum), 0);
                n++;
                if (!isst && n > 1 && stat_done) bad++;
            end
            if (st[c] == 8'hFE || st[c] > 8'h28) begin
                if (st[c] != 8'hFF) efail++;
            end
            if (st[c] != 8'h00 && st[c] != 8'hFF && st[c] != 8'hFE && st[c] <= 8'h28) begin
                esum += st[c]; if (st[c] > emax) emax = st[c];
            end
        end
        chk(stat_done == 1'b1, {"R8 done pulse ", tag}, int'(stat_done), 1);
        chk(stat_max == 8'(emax), {"R6 max ", tag}, int'(stat_max), emax);
        chk(stat_sum == 10'(esum), {"R6 R4 sum ", tag}, int'(stat_sum), esum);
        chk(stat_fail_cnt == 5'(efail), {"R5 fail count ", tag}, int'(stat_fail_cnt), efail);
        chk(stat_page_fail == (efail != 0), {"R5 page flag ", tag}, int'(stat_page_fail), int'(efail != 0));
        chk(ncap == step * chunks, {"R1 byte count ", tag}, ncap, step * chunks);
        for (int i = 0; i < ncap; i++) begin
            int c = i / step;
            if (cap[i] != 8'(seed + c * step + (i % step))) bad++;
            if (caplast[i] != (i == step * chunks - 1)) badlast++;
        end
        chk(bad == 0, {"R1 R7 data order ", tag}, bad, 0);
        chk(badlast == 0, {"R3 end marker ", tag}, badlast, 0);
        @(posedge clk); #1;
        chk(stat_done == 1'b0, {"R8 done single ", tag}, int'(stat_done), 0);
    endtask

    task automatic t_reset();
        chk(!stat_done && !out_valid && stat_sum == 0 && stat_max == 0 && stat_fail_cnt == 0 && !stat_page_fail,
            "R10 reset statistics", int'(stat_sum), 0);
        chk(in_ready == 1'b1, "R10 ready for spare", int'(in_ready), 1);
    endtask

    task automatic t_clean_and_corr();
        logic [7:0] st [16] = '{default: 8'h00};
        st[1] = 8'h05;
        run_page(3, 2, st, 8'h00, 1'b0, 8'h10, "basic");
    endtask

    task automatic t_mixed_backpressure();
        logic [7:0] st [16] = '{default: 8'h00};
        st[0] = 8'hFF; st[1] = 8'h28; st[2] = 8'h29; st[3] = 8'h03;
        run_page(2, 4, st, 8'h11, 1'b1, 8'h40, "mixed R4 R5 R6");
    endtask

    task automatic t_tail_bytes_ignored();
        logic [7:0] st [16] = '{default: 8'h00};
        run_page(4, 3, st, 8'hFE, 1'b1, 8'h80, "tail ignored R7");
    endtask

    task automatic t_min_step_max_chunks();
        logic [7:0] st [16] = '{default: 8'hFE};
        run_page(1, 16, st, 8'h07, 1'b0, 8'hC0, "step1 x16 fail");
    endtask

    task automatic t_max_step();
        logic [7:0] st [16] = '{default: 8'h00};
        st[0] = 8'h28;
        run_page(255, 1, st, 8'h00, 1'b0, 8'h01, "step255");
    endtask

    task automatic t_early_end();
        logic [7:0] st [16] = '{default: 8'h00};
        cfg_step = 8'd3; cfg_chunks = 5'd2; ncap = 0;
        for (int b = 0; b < 3; b++) send_byte(8'(b), 1'b0, 1'b1, 1'b0);
        send_byte(8'h07, 1'b0, 1'b1, 1'b1);
        send_byte(8'h00, 1'b1, 1'b1, 1'b1);
        chk(stat_done == 1'b0, "R9 no done after early end", int'(stat_done), 0);
        @(posedge clk); #1;
        chk(stat_done == 1'b0, "R9 no late done", int'(stat_done), 0);
        st[0] = 8'h01; st[1] = 8'h02;
        run_page(3, 2, st, 8'h00, 1'b0, 8'h20, "R9 resync");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean_and_corr();
        t_mixed_backpressure();
        t_tail_bytes_ignored();
        t_min_step_max_chunks();
        t_max_step();
        t_early_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule